// File: doc/BRIEF.md
# Inband Loopback Code Generator and Detector

This block handles remote loopback control on a T1 bit stream. A 2-bit mode input chooses one of four behaviours for the transmit path: plain pass-through, pass-through with a payload loopback request raised toward the surrounding datapath, or replacement of every payload bit with one of two repeating inband codes. The first code repeats with a period of five bits and asks the far end to close a line loopback. The second repeats with a period of three bits and asks it to open the loopback. Framing bit positions are never touched. The payload loopback request is meant for extended superframe links. The two inband codes are meant for superframe links.

On the receive side, the block watches payload bits for the same two codes and accepts them at any phase. Received bits are grouped into fixed windows of `WIN_BITS` payload bits, counted from reset. A code is declared when a whole window matches one phase of that code with fewer than one error per thousand bits. The two detect flags can never be high together. The newer valid detection replaces the older one, and a window that qualifies for neither code leaves the flags as they are. In a real link, `WIN_BITS` covers five seconds of payload. A simulation can set it much smaller.

Top module: `lbc_loop_ctrl`

## Requirements
- R1: With mode 00, every strobed transmit bit is copied to `tx_data_o` on the clock edge of its strobe. `payload_loop_o` stays low.
- R2: `payload_loop_o` is high in the cycle after mode 01 is present, and only then. In mode 01, transmit bits pass through unchanged.
- R3: With mode 10, payload bits are replaced by the repeating pattern 0,0,0,0,1. The fifth bit after the start is the one.
- R4: With mode 11, payload bits are replaced by the repeating pattern 0,0,1. The third bit after the start is the one.
- R5: A strobed bit marked as framing (`tx_frame_i`=1) is passed unchanged in every mode. It does not advance the code phase.
- R6: Any change of the mode value restarts the code at its first bit.
- R7: `tx_data_o` changes only on a cycle with `tx_vld_i` high. It holds its value otherwise.
- R8: A code is declared only at the end of a window of `WIN_BITS` received payload bits, counted from reset. The whole window must match a single phase of the code with fewer than `WIN_BITS/1000` mismatches. A window containing `WIN_BITS/1000` or more mismatches, or all-ones data, declares nothing.
- R9: Received bits marked as framing (`rx_frame_i`=1) are neither counted nor compared.
- R10: `det_up_o` and `det_down_o` are never high together. A qualifying window sets its own flag and clears the other. A window that qualifies for neither code keeps both flags unchanged.
- R11: Synchronous reset clears `tx_data_o`, `payload_loop_o`, both detect flags, the code phase and the receive window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Loopback mode: 00 normal, 01 payload loopback, 10 send up-code, 11 send down-code |
| tx_vld_i | input | 1 | Transmit bit strobe |
| tx_frame_i | input | 1 | Current transmit bit is a framing bit |
| tx_data_i | input | 1 | Transmit bit in |
| tx_data_o | output | 1 | Transmit bit out, registered |
| payload_loop_o | output | 1 | Payload loopback request |
| rx_vld_i | input | 1 | Receive bit strobe |
| rx_frame_i | input | 1 | Current receive bit is a framing bit |
| rx_data_i | input | 1 | Receive bit in |
| det_up_o | output | 1 | Up-code (period 5) detected |
| det_down_o | output | 1 | Down-code (period 3) detected |

## Verification
A wrong code phase shows up on `tx_data_o` at the next strobed payload bit: the one lands in the wrong place within five bits for the up-code and within three bits for the down-code. A framing bit that advances the phase shifts every later one by one position. A fault in the window counter or in an error counter stays hidden for a whole window, and then appears at the window boundary as a missing, early or wrong detect flag. For this reason, the flags are checked both one bit before and one bit after the boundary. Threshold faults show up in the window that has exactly the limiting number of errors.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {
    LB_NORMAL  = 2'b00,
    LB_PAYLOAD = 2'b01,
    LB_UP      = 2'b10,
    LB_DOWN    = 2'b11
  } lb_mode_e;

  localparam int UP_PERIOD   = 5;
  localparam int DOWN_PERIOD = 3;
  localparam int PH_W        = 3;
endpackage

// File: rtl/lbc_tx_gen.sv
module lbc_tx_gen
  import lbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       tx_vld_i,
  input  logic       tx_frame_i,
  input  logic       tx_data_i,
  output logic       tx_data_o,
  output logic       payload_loop_o
);
  logic [1:0]      mode_q;
  logic [PH_W-1:0] ph_q, ph_use, ph_last, ph_nx;
  logic            chg, code_on, pat_bit;

  always_comb begin
    chg     = (mode_i != mode_q);
    code_on = (mode_i == LB_UP) || (mode_i == LB_DOWN);
    ph_last = (mode_i == LB_UP) ? PH_W'(UP_PERIOD - 1) : PH_W'(DOWN_PERIOD - 1);
    ph_use  = chg ? '0 : ph_q;
    pat_bit = (ph_use == ph_last);
    ph_nx   = pat_bit ? '0 : ph_use + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q         <= LB_NORMAL;
      ph_q           <= '0;
      tx_data_o      <= 1'b0;
      payload_loop_o <= 1'b0;
    end else begin
      mode_q         <= mode_i;
      payload_loop_o <= (mode_i == LB_PAYLOAD);
      if (tx_vld_i && !tx_frame_i && code_on)
        ph_q <= ph_nx;
      else if (chg)
        ph_q <= '0;
      if (tx_vld_i)
        tx_data_o <= (code_on && !tx_frame_i) ? pat_bit : tx_data_i;
    end
  end
endmodule

// File: rtl/lbc_phase_match.sv
module lbc_phase_match #(
  parameter int PERIOD   = 5,
  parameter int WIN_BITS = 2000,
  localparam int CW      = $clog2(WIN_BITS + 1),
  localparam int PW      = $clog2(PERIOD + 1),
  localparam int ERR_LIM = WIN_BITS / 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic win_last,
  output logic hit
);
  logic [PW-1:0] pos_q;
  logic [PERIOD-1:0] ok;

  always_ff @(posedge clk) begin
    if (rst)
      pos_q <= '0;
    else if (bit_vld)
      pos_q <= (pos_q == PW'(PERIOD - 1)) ? '0 : pos_q + 1'b1;
  end

  for (genvar k = 0; k < PERIOD; k++) begin : g_phase
    logic [CW-1:0] err_q, err_nx;
    logic          miss;
    always_comb begin
      miss   = bit_in != (pos_q == PW'(k));
      err_nx = err_q + CW'(miss);
      ok[k]  = err_nx < CW'(ERR_LIM);
    end
    always_ff @(posedge clk) begin
      if (rst)
        err_q <= '0;
      else if (bit_vld)
        err_q <= win_last ? '0 : err_nx;
    end
  end

  assign hit = bit_vld && win_last && (|ok);
endmodule

// File: rtl/lbc_rx_det.sv
module lbc_rx_det
  import lbc_pkg::*;
#(
  parameter int WIN_BITS = 2000,
  localparam int WW      = $clog2(WIN_BITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_vld_i,
  input  logic rx_frame_i,
  input  logic rx_data_i,
  output logic det_up_o,
  output logic det_down_o
);
  logic [WW-1:0] wcnt_q;
  logic          bit_vld, win_last, hit_up, hit_dn;

  assign bit_vld  = rx_vld_i && !rx_frame_i;
  assign win_last = (wcnt_q == WW'(WIN_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst)
      wcnt_q <= '0;
    else if (bit_vld)
      wcnt_q <= win_last ? '0 : wcnt_q + 1'b1;
  end

  lbc_phase_match #(.PERIOD(UP_PERIOD), .WIN_BITS(WIN_BITS)) up_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(rx_data_i),
    .win_last(win_last), .hit(hit_up));

  lbc_phase_match #(.PERIOD(DOWN_PERIOD), .WIN_BITS(WIN_BITS)) dn_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(rx_data_i),
    .win_last(win_last), .hit(hit_dn));

  always_ff @(posedge clk) begin
    if (rst) begin
      det_up_o   <= 1'b0;
      det_down_o <= 1'b0;
    end else if (hit_up) begin
      det_up_o   <= 1'b1;
      det_down_o <= 1'b0;
    end else if (hit_dn) begin
      det_up_o   <= 1'b0;
      det_down_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lbc_loop_ctrl.sv
module lbc_loop_ctrl #(
  parameter int WIN_BITS = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       tx_vld_i,
  input  logic       tx_frame_i,
  input  logic       tx_data_i,
  output logic       tx_data_o,
  output logic       payload_loop_o,
  input  logic       rx_vld_i,
  input  logic       rx_frame_i,
  input  logic       rx_data_i,
  output logic       det_up_o,
  output logic       det_down_o
);
  lbc_tx_gen tx_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .tx_vld_i(tx_vld_i),
    .tx_frame_i(tx_frame_i), .tx_data_i(tx_data_i),
    .tx_data_o(tx_data_o), .payload_loop_o(payload_loop_o));

  lbc_rx_det #(.WIN_BITS(WIN_BITS)) rx_i (
    .clk(clk), .rst(rst), .rx_vld_i(rx_vld_i), .rx_frame_i(rx_frame_i),
    .rx_data_i(rx_data_i), .det_up_o(det_up_o), .det_down_o(det_down_o));
endmodule

// File: rtl/lbc_loop_ctrl_chk.sv
module lbc_loop_ctrl_chk #(
  parameter int WIN_BITS = 2000,
  localparam int WW      = $clog2(WIN_BITS)
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       tx_vld_i,
  input logic       tx_frame_i,
  input logic       tx_data_i,
  input logic       tx_data_o,
  input logic       payload_loop_o,
  input logic       rx_vld_i,
  input logic       rx_frame_i,
  input logic       det_up_o,
  input logic       det_down_o
);
  logic [WW-1:0] cnt_q;
  logic          boundary;

  assign boundary = rx_vld_i && !rx_frame_i && (cnt_q == WW'(WIN_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (rx_vld_i && !rx_frame_i)
      cnt_q <= (cnt_q == WW'(WIN_BITS - 1)) ? '0 : cnt_q + 1'b1;
  end

  AST_DET_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(det_up_o && det_down_o)); // R10

  AST_PAYLOAD_REQ: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b01) |=> payload_loop_o); // R2

  AST_PAYLOAD_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'b01) |=> !payload_loop_o); // R2

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (tx_vld_i && mode_i == 2'b00) |=> (tx_data_o == $past(tx_data_i))); // R1

  AST_FRAME_PASS: assert property (@(posedge clk) disable iff (rst)
    (tx_vld_i && tx_frame_i) |=> (tx_data_o == $past(tx_data_i))); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tx_vld_i |=> $stable(tx_data_o)); // R7

  AST_DET_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(det_up_o) && $stable(det_down_o))); // R8
endmodule

bind lbc_loop_ctrl lbc_loop_ctrl_chk #(.WIN_BITS(WIN_BITS)) chk_i (
  .clk(clk), .rst(rst), .mode_i(mode_i), .tx_vld_i(tx_vld_i),
  .tx_frame_i(tx_frame_i), .tx_data_i(tx_data_i), .tx_data_o(tx_data_o),
  .payload_loop_o(payload_loop_o), .rx_vld_i(rx_vld_i),
  .rx_frame_i(rx_frame_i), .det_up_o(det_up_o), .det_down_o(det_down_o));

// File: tb/lbc_loop_ctrl_tb_top.sv
module lbc_loop_ctrl_tb_top;
  localparam int WIN = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic tx_vld_i = 1'b0, tx_frame_i = 1'b0, tx_data_i = 1'b0;
  logic rx_vld_i = 1'b0, rx_frame_i = 1'b0, rx_data_i = 1'b0;
  logic tx_data_o, payload_loop_o, det_up_o, det_down_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lbc_loop_ctrl #(.WIN_BITS(WIN)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .tx_vld_i(tx_vld_i),
    .tx_frame_i(tx_frame_i), .tx_data_i(tx_data_i), .tx_data_o(tx_data_o),
    .payload_loop_o(payload_loop_o), .rx_vld_i(rx_vld_i),
    .rx_frame_i(rx_frame_i), .rx_data_i(rx_data_i),
    .det_up_o(det_up_o), .det_down_o(det_down_o));

  // {mode[1:0], frame, din, expected out, expected payload_loop, 2'b0, req[3:0]}
  localparam int NV = 17;
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 2'b0, 4'd1},  // R1 pass
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, 4'd1},  // R1 pass
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 2'b0, 4'd6},  // R6 start of up-code
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 2'b0, 4'd3},  // R3
    {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b0, 4'd5},  // R5 framing passes
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 2'b0, 4'd3},  // R3
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, 4'd3},  // R3
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 2'b0, 4'd3},  // R3 fifth bit is one
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 2'b0, 4'd3},  // R3 wrap
    {2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 2'b0, 4'd6},  // R6 restart on change
    {2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 2'b0, 4'd4},  // R4
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 2'b0, 4'd4},  // R4 third bit is one
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 2'b0, 4'd5},  // R5 framing passes
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, 4'd4},  // R4 wrap
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, 4'd6},  // R6 restart from down-code
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 2'b0, 4'd2},  // R2 payload loop
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 2'b0, 4'd2}   // R2 payload loop
  };

  function automatic string rname(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kind 0 up-code, 1 down-code, 2 all ones; flips at bits 500*k+3 for k < nerr
  task automatic feed(input int kind, input int off, input int nerr, input bit frames,
                      input int first, input int last);
    for (int i = first; i < last; i++) begin
      logic b;
      if (frames && (i % 50 == 0)) begin
        @(negedge clk);
        rx_vld_i = 1'b1; rx_frame_i = 1'b1; rx_data_i = (i % 100 == 0);
      end
      case (kind)
        0: b = ((i + off) % 5 == 4);
        1: b = ((i + off) % 3 == 2);
        default: b = 1'b1;
      endcase
      for (int k = 0; k < nerr; k++)
        if (i == 500 * k + 3) b = ~b;
      @(negedge clk);
      rx_vld_i = 1'b1; rx_frame_i = 1'b0; rx_data_i = b;
    end
    @(negedge clk);
    rx_vld_i = 1'b0; rx_frame_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset outputs", {tx_data_o, payload_loop_o, det_up_o, det_down_o}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      mode_i = VEC[v][11:10]; tx_frame_i = VEC[v][9]; tx_data_i = VEC[v][8];
      tx_vld_i = 1'b1;
      @(negedge clk);
      check(rname(int'(VEC[v][3:0])), $sformatf("vector %0d", v),
            {2'b00, tx_data_o, payload_loop_o}, {2'b00, VEC[v][7], VEC[v][6]});
    end

    // R7 no strobe: output holds while input and mode change
    tx_vld_i = 1'b0; tx_data_i = 1'b1; mode_i = 2'b00; tx_frame_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", "hold without strobe", {3'b0, tx_data_o}, 4'b0000);
    check("R2", "payload loop dropped", {3'b0, payload_loop_o}, 4'b0000);

    // R8 up-code, one error, not declared before the window ends
    feed(0, 2, 1, 1'b0, 0, WIN - 1);
    check("R8", "no early detect", {2'b0, det_up_o, det_down_o}, 4'b0000);
    feed(0, 2, 1, 1'b0, WIN - 1, WIN);
    check("R8", "up-code detected", {2'b0, det_up_o, det_down_o}, 4'b0010);

    // R8 down-code with errors at the limit: nothing declared, R10 flags hold
    feed(1, 0, 2, 1'b0, 0, WIN);
    check("R10", "hold on failed window", {2'b0, det_up_o, det_down_o}, 4'b0010);

    // R10 clean down-code replaces up
    feed(1, 1, 0, 1'b0, 0, WIN);
    check("R10", "down replaces up", {2'b0, det_up_o, det_down_o}, 4'b0001);

    // R9 framing bits interleaved are ignored
    feed(0, 0, 1, 1'b1, 0, WIN);
    check("R9", "up-code with framing bits", {2'b0, det_up_o, det_down_o}, 4'b0010);

    // R8 all ones matches neither
    feed(2, 0, 0, 1'b0, 0, WIN);
    check("R8", "all ones no change", {2'b0, det_up_o, det_down_o}, 4'b0010);

    // R11 reset clears flags
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "reset clears detect", {2'b0, det_up_o, det_down_o}, 4'b0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule